// File: doc/BRIEF.md
# Strap-Latched Address and LED Pin Controller

This block controls five shared bidirectional pins that have two jobs. While the chip is in reset, the pins are inputs. Board-level pull-ups or pull-downs on them set a 5-bit management address. When reset is released, the block latches that address and turns the same pins into LED drivers. From then on the pins show link activity, collisions, link integrity, transmitted data and received data.

Each LED pin's drive polarity comes from the address bit captured on that pin. A pin strapped high pulls low to light its LED. A pin strapped low drives high to light its LED. So the LED always conducts current away from the rail the pin is strapped to.

Activity, collision, transmit and receive events are short pulses from the PHY core. Each one is stretched by a retriggerable counter so that it stays visible. The link-integrity LED follows the link level directly.

The pin sequencing is a three-state machine:
- `ST_SAMPLE`: the state held during reset. The drivers are off and the pins pass through a two-flop synchronizer.
- `SAMPLE -> SETTLE`: taken on the first clock edge after reset release. The synchronized levels are latched into the address at this edge.
- `ST_SETTLE`: lasts one cycle with the drivers still off.
- `SETTLE -> DRIVE`: turns on all five output enables.
- `ST_DRIVE`: held until the next reset.

Top module: `strap_led_ctrl`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 5'b00000, `mgmt_addr_valid` is 0 and `mgmt_addr` is 0.
- R2: On the first rising clock edge after `rst_n` goes high, `mgmt_addr[i]` takes the level of `pin_in[i]` for i = 0..4, provided those levels were held for at least two cycles before release. `mgmt_addr_valid` rises at that same edge.
- R3: One clock edge after the capture edge, `pin_oe` becomes 5'b11111. It stays there until the next reset.
- R4: After the capture, `mgmt_addr` does not change, whatever `pin_in` does, until the next reset.
- R5: While enabled, `pin_out[i]` equals `mgmt_addr[i]` XOR lit(i). A dark LED drives its strap level, and a lit LED drives the inverse.
- R6: The pin assignment is fixed: bit 0 is activity, bit 1 is collision, bit 2 is link integrity, bit 3 is transmit data and bit 4 is receive data.
- R7: A single-cycle event pulse sampled at a clock edge lights its LED starting after that edge. The LED stays lit for exactly `STRETCH_CYCLES` cycles and then goes dark.
- R8: An event that arrives while its LED is lit restarts the full `STRETCH_CYCLES` on-time from that event.
- R9: The link-integrity pin follows `link_up` combinationally, with no stretching and no clock delay.
- R10: A later reset clears the address and the valid flag and disables the drivers. On its release, the block captures the pin levels present at that time.
- R11: While a pin's output enable is low, its `pin_out` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap sampling window |
| pin_in | input | 5 | Levels read from the five shared pins |
| pin_out | output | 5 | Drive values for the five shared pins |
| pin_oe | output | 5 | Output enables for the five shared pins |
| evt_activity | input | 1 | Link activity event pulse |
| evt_collision | input | 1 | Collision event pulse |
| link_up | input | 1 | Link integrity level |
| evt_tx | input | 1 | Transmit data event pulse |
| evt_rx | input | 1 | Receive data event pulse |
| mgmt_addr | output | 5 | Latched management address |
| mgmt_addr_valid | output | 1 | High once the address has been captured |

## Verification
The hardest case to reach from the ports is a second reset that arrives while stretch counters are still running, with a different strap pattern on the pins. Getting it right needs a fresh capture, fresh polarities and cleared LED timers all at once. The stimulus runs a random event phase with one strap value, then asserts reset again in the middle of traffic with a new strap value, and checks the capture and the polarity flip. Retrigger timing and exact on-time are reached by directed pulse trains with a short stretch parameter. Randomly toggling pin inputs after release probe the address hold.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;

    localparam int unsigned NUM_PINS = 5;

    // Pin positions; the polarity of each is tied to the strap captured on it
    localparam int unsigned PIN_ACT  = 0;
    localparam int unsigned PIN_COL  = 1;
    localparam int unsigned PIN_LINK = 2;
    localparam int unsigned PIN_TX   = 3;
    localparam int unsigned PIN_RX   = 4;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DRIVE  = 2'd2
    } pin_state_e;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    // No reset: the chain must keep sampling while reset is held
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        chain[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            chain[s] <= chain[s-1];
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/event_stretch.sv
module event_stretch #(
    parameter int unsigned STRETCH_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic lit
);

    localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYCLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (evt) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign lit = (remain != '0);

endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
    import strap_led_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 65536,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic                evt_activity,
    input  logic                evt_collision,
    input  logic                link_up,
    input  logic                evt_tx,
    input  logic                evt_rx,
    output logic [NUM_PINS-1:0] mgmt_addr,
    output logic                mgmt_addr_valid
);

    pin_state_e state_q, state_d;
    logic [NUM_PINS-1:0] strap_sync_lv;
    logic [NUM_PINS-1:0] addr_q;
    logic                valid_q;
    logic [NUM_PINS-1:0] evt_vec;
    logic [NUM_PINS-1:0] lit_vec;
    logic                drive_en;

    strap_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .d_in  (pin_in),
        .d_out (strap_sync_lv)
    );

    // Event routing per pin position
    always_comb begin
        evt_vec           = '0;
        evt_vec[PIN_ACT]  = evt_activity;
        evt_vec[PIN_COL]  = evt_collision;
        evt_vec[PIN_TX]   = evt_tx;
        evt_vec[PIN_RX]   = evt_rx;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_led
        if (i == PIN_LINK) begin : g_level
            assign lit_vec[i] = link_up;
        end else begin : g_pulse
            event_stretch #(
                .STRETCH_CYCLES (STRETCH_CYCLES)
            ) u_stretch (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (evt_vec[i]),
                .lit   (lit_vec[i])
            );
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_DRIVE;
            ST_DRIVE:  state_d = ST_DRIVE;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    // Address capture on the SAMPLE -> SETTLE edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else if (state_q == ST_SAMPLE) begin
            addr_q  <= strap_sync_lv;
            valid_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        drive_en = 1'b0;
        unique case (state_q)
            ST_SAMPLE: drive_en = 1'b0;
            ST_SETTLE: drive_en = 1'b0;
            ST_DRIVE:  drive_en = 1'b1;
            default:   drive_en = 1'b0;
        endcase
        pin_oe  = {NUM_PINS{drive_en}};
        pin_out = drive_en ? (addr_q ^ lit_vec) : '0;
    end

    assign mgmt_addr       = addr_q;
    assign mgmt_addr_valid = valid_q;

endmodule

// File: rtl/strap_led_chk.sv
module strap_led_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] pin_oe,
    input logic [4:0] pin_out,
    input logic [4:0] mgmt_addr,
    input logic       mgmt_addr_valid,
    input logic       link_up,
    input logic       evt_activity
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst_n)
        (pin_oe == 5'b0) && !mgmt_addr_valid && (mgmt_addr == 5'b0));

    // R3
    oe_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_addr_valid) |=> (pin_oe == 5'b11111));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_addr_valid && $past(mgmt_addr_valid)) |-> $stable(mgmt_addr));

    // R9
    link_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[2] |-> (pin_out[2] == (mgmt_addr[2] ^ link_up)));

    // R7
    act_lights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_activity && pin_oe[0]) |=> (pin_out[0] != mgmt_addr[0]));

    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == 5'b0) |-> (pin_out == 5'b0));

endmodule

bind strap_led_ctrl strap_led_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pin_oe          (pin_oe),
    .pin_out         (pin_out),
    .mgmt_addr       (mgmt_addr),
    .mgmt_addr_valid (mgmt_addr_valid),
    .link_up         (link_up),
    .evt_activity    (evt_activity)
);

// File: tb/strap_led_ctrl_bench.sv
module strap_led_ctrl_bench;

    localparam int CLK_P   = 10;
    localparam int STRETCH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pin_in = 5'b0;
    logic [4:0] pin_out, pin_oe, mgmt_addr;
    logic       mgmt_addr_valid;
    logic       evt_activity = 0, evt_collision = 0, link_up = 0, evt_tx = 0, evt_rx = 0;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt [5];
    logic [4:0] exp_addr;
    bit done = 0;

    strap_led_ctrl #(.STRETCH_CYCLES(STRETCH)) u_strap_led_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .evt_activity(evt_activity), .evt_collision(evt_collision), .link_up(link_up),
        .evt_tx(evt_tx), .evt_rx(evt_rx), .mgmt_addr(mgmt_addr), .mgmt_addr_valid(mgmt_addr_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] lit_exp();
        logic [4:0] l;
        for (int i = 0; i < 5; i++) l[i] = (cnt[i] > 0);
        l[2] = link_up;
        return l;
    endfunction

    function automatic logic [4:0] out_exp();
        return exp_addr ^ lit_exp();
    endfunction

    // Called just after a negedge: apply inputs, advance model, sample after posedge
    task automatic tick(input logic [4:0] ev, input logic lk);
        logic [4:0] evs;
        evt_activity = ev[0]; evt_collision = ev[1]; evt_tx = ev[3]; evt_rx = ev[4];
        link_up = lk;
        evs = ev;
        for (int i = 0; i < 5; i++) begin
            if (i != 2) begin
                if (evs[i]) cnt[i] = STRETCH;
                else if (cnt[i] > 0) cnt[i] = cnt[i] - 1;
            end
        end
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic to_neg();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [4:0] strap);
        @(negedge clk);
        rst_n = 0;
        pin_in = strap;
        evt_activity = 0; evt_collision = 0; evt_tx = 0; evt_rx = 0; link_up = 0;
        for (int i = 0; i < 5; i++) cnt[i] = 0;
        repeat (4) @(negedge clk);
        // R1
        check(pin_oe == 5'b0 && !mgmt_addr_valid && mgmt_addr == 5'b0, "R1/R10 reset state",
              {pin_oe, mgmt_addr_valid, mgmt_addr}, 0);
        check(pin_out == 5'b0, "R11 idle pins low", pin_out, 0);
        rst_n = 1;
        exp_addr = strap;
        tick(5'b0, 1'b0);
        // R2
        check(mgmt_addr == strap && mgmt_addr_valid, "R2 capture", {mgmt_addr_valid, mgmt_addr}, {1'b1, strap});
        check(pin_oe == 5'b0, "R3 drivers off in settle", pin_oe, 0);
        to_neg();
        pin_in = ~strap;
        tick(5'b0, 1'b0);
        // R3
        check(pin_oe == 5'b11111, "R3 enable", pin_oe, 5'h1f);
        // R5
        check(pin_out == strap, "R5 dark drives strap", pin_out, strap);
        to_neg();
    endtask

    task automatic random_phase(input int n);
        for (int k = 0; k < n; k++) begin
            logic [4:0] ev;
            logic lk;
            ev = 5'b0;
            for (int i = 0; i < 5; i++) ev[i] = ($urandom % 8) == 0;
            lk = $urandom % 2;
            pin_in = $urandom;
            tick(ev, lk);
            // R6 / R5
            check(pin_out == out_exp(), "R6 pin mapping and R5 polarity", pin_out, out_exp());
            // R4
            check(mgmt_addr == exp_addr, "R4 address hold", mgmt_addr, exp_addr);
            to_neg();
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int lit_cycles;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 5; i++) cnt[i] = 0;
        exp_addr = 0;

        do_reset(5'b10110);

        // R7: exact on-time of one pulse
        lit_cycles = 0;
        tick(5'b00001, 1'b0);
        if (pin_out[0] != exp_addr[0]) lit_cycles++;
        to_neg();
        for (int k = 0; k < 12; k++) begin
            tick(5'b0, 1'b0);
            if (pin_out[0] != exp_addr[0]) lit_cycles++;
            to_neg();
        end
        check(lit_cycles == STRETCH, "R7 stretch length", lit_cycles, STRETCH);

        // R8: retrigger three cycles after the first pulse
        lit_cycles = 0;
        for (int k = 0; k < 16; k++) begin
            tick((k == 0 || k == 3) ? 5'b10000 : 5'b0, 1'b0);
            if (pin_out[4] != exp_addr[4]) lit_cycles++;
            to_neg();
        end
        check(lit_cycles == STRETCH + 3, "R8 retrigger", lit_cycles, STRETCH + 3);

        // R9: link pin follows level without a clock edge
        link_up = 1;
        #1;
        check(pin_out[2] == ~exp_addr[2], "R9 link lit", pin_out[2], ~exp_addr[2]);
        link_up = 0;
        #1;
        check(pin_out[2] == exp_addr[2], "R9 link dark", pin_out[2], exp_addr[2]);

        random_phase(300);

        // R10: reset mid-traffic with an inverted strap
        tick(5'b11011, 1'b1);
        do_reset(5'b01001);
        check(pin_out == 5'b01001, "R10 new polarity and cleared timers", pin_out, 5'b01001);
        random_phase(300);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule